// File: doc/BRIEF.md
# Phase-Sampled Vectoring Interrupt Controller

This block is the interrupt unit of a small processor core. The core runs each instruction cycle in four clock phases, Q1 to Q4. The block holds the enable and request bits for three direct sources (a timer, an external pin and a port-change detector) and for a group of peripheral sources. It produces a request that is gated by a global enable and, for the peripheral group, by a group enable. Software reaches all of these bits through a small register port. Each source event sets its request flag, and only a software write of zero clears it.

The external pin goes through a two-stage synchroniser and a rising-edge detector before it sets its flag. A pending, enabled request is recognised only on the clock edge that closes phase Q1. Once a request is recognised, the block clears the global enable and raises `dummy` for a fixed number of instruction cycles, during which the core discards its prefetched instruction and saves its return address. At the end it pulses `vec_load` together with the fixed vector address. A return strobe from the core sets the global enable again.

Top module: `qint_ctrl`

## Requirements
- R1: While reset is high and after it is released, every register reads 0x00. During reset `irq` and `dummy` are 0 and `phase` is 0. Phase codes are 0 for Q1 through 3 for Q4, and `phase` advances by one on every clock after reset.
- R2: The register at address 0 is the control register. Its bits, from 7 down to 0, are: global enable, peripheral-group enable, timer enable, pin enable, port-change enable, timer flag, pin flag and port-change flag. Address 1 holds the peripheral enables and address 2 the peripheral flags, with bit i belonging to `per_evt[i]`. Address 3 reads 0 and ignores writes. `reg_rdata` shows the addressed register one clock after the address is applied.
- R3: A source event sets its flag whatever the state of its enable. A flag is cleared only by writing 0 to it. If an event and a clearing write fall in the same clock, the flag stays set.
- R4: A rising edge on `ext_pin` sets the pin flag on the third clock edge after the pin changes. Holding the pin high, or a falling edge, does not set the flag again.
- R5: `irq` is registered. It is 1 when the global enable is set and at least one of the following holds: a direct source has both its flag and its enable set, or the group enable is set and some peripheral has both its enable and its flag set.
- R6: Recognition happens only on the clock edge at which `phase` is 0 and `irq` is 1, and never while an entry is in progress. `dummy` then stays high for exactly 8 clocks (two instruction cycles). `vec_load` pulses for one clock, with `phase` equal to 1, in the clock after `dummy` falls, and `vec_addr` is 0x004. A synchronous source event or enabling write applied before clock edge n+1 leads to recognition at the first Q1 edge at or after edge n+3. For the pin, that first edge is at or after n+5.
- R7: The global enable bit reads 0 from the clock after recognition, so a still-set flag does not cause a second entry.
- R8: A `reti` pulse sets the global enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock (four clocks per instruction cycle) |
| rst | input | 1 | Synchronous active-high reset |
| ext_pin | input | 1 | Asynchronous external interrupt pin |
| t0_evt | input | 1 | Timer overflow event pulse |
| pc_evt | input | 1 | Port-change event pulse |
| per_evt | input | NPER | Peripheral event pulses, one per source |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data |
| reti | input | 1 | Return-from-interrupt strobe |
| irq | output | 1 | Gated pending request |
| phase | output | 2 | Current phase, 0 = Q1 ... 3 = Q4 |
| dummy | output | 1 | High during the dummy entry cycles |
| vec_load | output | 1 | One-clock strobe to load the vector into the program counter |
| vec_addr | output | VEC_W | Fixed interrupt vector |

## Verification
The assertions check on every clock the entry sequence's relation to the phase counter: `dummy` rises and `vec_load` fires only in phase Q2, `vec_load` follows the fall of `dummy` and is never two clocks long, and the global enable is off once an entry starts. They also check that `irq` never appears without the global enable in the previous clock, and that a return strobe sets the enable. Other behaviours can only be shown by the bench's scenarios: the exact clock of each vector load for timer, pin and enabling-write sources; the three-edge delay of the pin synchroniser; the priority of an event over a clearing write; the group gating of the peripheral sources; and the register layout.

// File: rtl/qint_pkg.sv
package qint_pkg;
  localparam int NPHASE = 4;
  localparam int PH_W   = $clog2(NPHASE);

  localparam logic [1:0] A_CTL  = 2'd0;
  localparam logic [1:0] A_PEN  = 2'd1;
  localparam logic [1:0] A_PREQ = 2'd2;

  // control register bit positions
  localparam int B_GIE  = 7;
  localparam int B_GRP  = 6;
  localparam int B_T0E  = 5;
  localparam int B_PINE = 4;
  localparam int B_PCE  = 3;
  localparam int B_T0F  = 2;
  localparam int B_PINF = 1;
  localparam int B_PCF  = 0;
endpackage

// File: rtl/qint_sync_edge.sv
module qint_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [STAGES-1:0] sh;
  logic              prev;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk)
        if (rst) sh[0] <= 1'b0;
        else     sh[0] <= din;
    end else begin : g_next
      always_ff @(posedge clk)
        if (rst) sh[i] <= 1'b0;
        else     sh[i] <= sh[i-1];
    end
  end

  always_ff @(posedge clk)
    if (rst) prev <= 1'b0;
    else     prev <= sh[STAGES-1];

  assign rise = sh[STAGES-1] & ~prev;
endmodule

// File: rtl/qint_regs.sv
module qint_regs
  import qint_pkg::*;
#(
  parameter int NPER = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr,
  input  logic [1:0]      addr,
  input  logic [7:0]      wdata,
  input  logic            t0_evt,
  input  logic            pin_rise,
  input  logic            pc_evt,
  input  logic [NPER-1:0] per_evt,
  input  logic            reti,
  input  logic            take,
  output logic [7:0]      rdata,
  output logic            irq,
  output logic            gie
);
  logic [7:0]      ctl_q, ctl_n;
  logic [NPER-1:0] pie_q, pie_n, pir_q, pir_n;
  logic            irq_c;
  logic [7:0]      rd_c;

  always_comb begin
    ctl_n = ctl_q;
    if (wr && addr == A_CTL) ctl_n = wdata;
    if (t0_evt)   ctl_n[B_T0F]  = 1'b1;
    if (pin_rise) ctl_n[B_PINF] = 1'b1;
    if (pc_evt)   ctl_n[B_PCF]  = 1'b1;
    if (reti)     ctl_n[B_GIE]  = 1'b1;
    if (take)     ctl_n[B_GIE]  = 1'b0;

    pie_n = (wr && addr == A_PEN) ? wdata[NPER-1:0] : pie_q;
    pir_n = ((wr && addr == A_PREQ) ? wdata[NPER-1:0] : pir_q) | per_evt;

    irq_c = ctl_q[B_GIE] &
            ((ctl_q[B_T0E]  & ctl_q[B_T0F])  |
             (ctl_q[B_PINE] & ctl_q[B_PINF]) |
             (ctl_q[B_PCE]  & ctl_q[B_PCF])  |
             (ctl_q[B_GRP]  & (|(pie_q & pir_q))));

    case (addr)
      A_CTL:   rd_c = ctl_q;
      A_PEN:   rd_c = 8'(pie_q);
      A_PREQ:  rd_c = 8'(pir_q);
      default: rd_c = 8'h00;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= '0;
      pie_q <= '0;
      pir_q <= '0;
      irq   <= 1'b0;
      rdata <= '0;
    end else begin
      ctl_q <= ctl_n;
      pie_q <= pie_n;
      pir_q <= pir_n;
      irq   <= irq_c;
      rdata <= rd_c;
    end
  end

  assign gie = ctl_q[B_GIE];
endmodule

// File: rtl/qint_seq.sv
module qint_seq
  import qint_pkg::*;
#(
  parameter int DUMMY_CYC = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            irq,
  output logic [PH_W-1:0] phase,
  output logic            take,
  output logic            dummy,
  output logic            vec_load
);
  localparam int CNT_W = $clog2(DUMMY_CYC + 1);

  logic [PH_W-1:0]  ph_q;
  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             at_q1;

  assign at_q1 = (ph_q == '0);
  assign take  = at_q1 & ~busy & irq;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q     <= '0;
      busy     <= 1'b0;
      cnt      <= '0;
      vec_load <= 1'b0;
    end else begin
      ph_q     <= ph_q + 1'b1;
      vec_load <= at_q1 & busy & (cnt == '0);
      if (take) begin
        busy <= 1'b1;
        cnt  <= CNT_W'(DUMMY_CYC - 1);
      end else if (at_q1 && busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - 1'b1;
      end
    end
  end

  assign phase = ph_q;
  assign dummy = busy;
endmodule

// File: rtl/qint_ctrl.sv
module qint_ctrl
  import qint_pkg::*;
#(
  parameter int NPER      = 8,
  parameter int VEC_W     = 13,
  parameter int VECTOR    = 4,
  parameter int DUMMY_CYC = 2,
  parameter int SYNC_STG  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_pin,
  input  logic             t0_evt,
  input  logic             pc_evt,
  input  logic [NPER-1:0]  per_evt,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [7:0]       reg_wdata,
  output logic [7:0]       reg_rdata,
  input  logic             reti,
  output logic             irq,
  output logic [1:0]       phase,
  output logic             dummy,
  output logic             vec_load,
  output logic [VEC_W-1:0] vec_addr
);
  logic pin_rise;
  logic take;
  logic gie_w;

  qint_sync_edge #(.STAGES(SYNC_STG)) u_pin (
    .clk(clk), .rst(rst), .din(ext_pin), .rise(pin_rise)
  );

  qint_regs #(.NPER(NPER)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .t0_evt(t0_evt), .pin_rise(pin_rise), .pc_evt(pc_evt), .per_evt(per_evt),
    .reti(reti), .take(take), .rdata(reg_rdata), .irq(irq), .gie(gie_w)
  );

  qint_seq #(.DUMMY_CYC(DUMMY_CYC)) u_seq (
    .clk(clk), .rst(rst), .irq(irq), .phase(phase), .take(take),
    .dummy(dummy), .vec_load(vec_load)
  );

  assign vec_addr = VEC_W'(VECTOR);
endmodule

// File: rtl/qint_ctrl_chk.sv
module qint_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       irq,
  input logic       dummy,
  input logic       vec_load,
  input logic       reti,
  input logic       gie,
  input logic [1:0] phase
);
  AST_DUMMY_START_Q2: assert property (@(posedge clk) disable iff (rst)
    $rose(dummy) |-> phase == 2'd1); // R6
  AST_VLOAD_IN_Q2: assert property (@(posedge clk) disable iff (rst)
    vec_load |-> phase == 2'd1); // R6
  AST_VLOAD_AFTER_DUMMY: assert property (@(posedge clk) disable iff (rst)
    $fell(dummy) |-> vec_load); // R6
  AST_VLOAD_SINGLE: assert property (@(posedge clk) disable iff (rst)
    vec_load |=> !vec_load); // R6
  AST_GIE_OFF_ON_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(dummy) |-> !gie); // R7
  AST_IRQ_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(gie)); // R5
  AST_RETI_SETS_GIE: assert property (@(posedge clk) disable iff (rst)
    (reti && dummy) |=> gie); // R8
endmodule

bind qint_ctrl qint_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .irq(irq), .dummy(dummy), .vec_load(vec_load),
  .reti(reti), .gie(gie_w), .phase(phase)
);

// File: tb/qint_ctrl_bench.sv
`timescale 1ns/1ps
module qint_ctrl_bench;
  localparam int NPER  = 8;
  localparam int VEC_W = 13;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ext_pin = 1'b0, t0_evt = 1'b0, pc_evt = 1'b0, reti = 1'b0;
  logic [NPER-1:0]  per_evt = '0;
  logic             reg_wr = 1'b0;
  logic [1:0]       reg_addr = 2'd0;
  logic [7:0]       reg_wdata = 8'h00;
  logic [7:0]       reg_rdata;
  logic             irq, dummy, vec_load;
  logic [1:0]       phase;
  logic [VEC_W-1:0] vec_addr;

  int checks = 0, failures = 0, cyc = 0, dcnt = 0;
  int exp_q[$];
  logic [7:0] rd;

  qint_ctrl u_qint_ctrl (
    .clk(clk), .rst(rst), .ext_pin(ext_pin), .t0_evt(t0_evt), .pc_evt(pc_evt),
    .per_evt(per_evt), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .reti(reti), .irq(irq), .phase(phase), .dummy(dummy),
    .vec_load(vec_load), .vec_addr(vec_addr)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // clock count at which vec_load is seen, given the drive point and source delay
  function automatic int exp_vload(input int n, input int ph, input int d);
    int m = n + d;
    while (((ph + m - n - 1) % 4) != 0) m++;
    return m + 8;
  endfunction

  // driver side: push expected vector-load time for the stimulus applied now
  task automatic expect_entry(input int d);
    exp_q.push_back(exp_vload(cyc, int'(phase), d));
  endtask

  // monitor: compare each vector load against the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (dummy) dcnt++;
      if (vec_load) begin
        if (exp_q.size() == 0) chk("R6 unexpected vec_load", cyc, -1);
        else chk("R6 vec_load clock", cyc, exp_q.pop_front());
        chk("R6 dummy length", dcnt, 8);
        chk("R6 vector address", int'(vec_addr), 4);
        dcnt = 0;
      end
    end
  end

  initial begin
    #(200000 * 4);
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int n;
    idle(3);
    chk("R1 irq in reset", int'(irq), 0);
    chk("R1 dummy in reset", int'(dummy), 0);
    chk("R1 phase in reset", int'(phase), 0);
    chk("R1 rdata in reset", int'(reg_rdata), 0);
    rst = 1'b0;
    rd_reg(2'd0, rd); chk("R1 ctl after reset", rd, 0);
    rd_reg(2'd1, rd); chk("R1 pen after reset", rd, 0);
    rd_reg(2'd2, rd); chk("R1 preq after reset", rd, 0);

    // R2 layout and address map
    wr_reg(2'd0, 8'h38); rd_reg(2'd0, rd); chk("R2 ctl readback", rd, 8'h38);
    wr_reg(2'd1, 8'hA5); rd_reg(2'd1, rd); chk("R2 pen readback", rd, 8'hA5);
    wr_reg(2'd3, 8'hFF); rd_reg(2'd3, rd); chk("R2 addr3 reads zero", rd, 0);
    wr_reg(2'd1, 8'h00);

    // R3 event sets flag regardless of enable; event beats clearing write
    wr_reg(2'd0, 8'h18);
    t0_evt = 1'b1; @(negedge clk); t0_evt = 1'b0;
    rd_reg(2'd0, rd); chk("R3 timer flag set while disabled", rd, 8'h1C);
    chk("R5 no irq without global enable", int'(irq), 0);
    t0_evt = 1'b1; wr_reg(2'd0, 8'h18); t0_evt = 1'b0;
    rd_reg(2'd0, rd); chk("R3 event wins over clear", rd, 8'h1C);
    wr_reg(2'd0, 8'h18); rd_reg(2'd0, rd); chk("R3 cleared by write 0", rd, 8'h18);

    // R4 pin synchroniser timing
    wr_reg(2'd0, 8'h00);
    reg_addr = 2'd0;
    n = cyc; ext_pin = 1'b1;
    while (cyc < n + 3) @(negedge clk);
    chk("R4 pin flag not yet set", int'(reg_rdata[1]), 0);
    @(negedge clk);
    chk("R4 pin flag on third edge", int'(reg_rdata[1]), 1);
    wr_reg(2'd0, 8'h00); idle(6);
    rd_reg(2'd0, rd); chk("R4 held level does not retrigger", rd, 0);
    ext_pin = 1'b0; idle(6);
    rd_reg(2'd0, rd); chk("R4 falling edge ignored", rd, 0);

    // R5 direct source enabled but global off, then R6/R7 entry via timer
    wr_reg(2'd0, 8'h20);
    t0_evt = 1'b1; @(negedge clk); t0_evt = 1'b0; idle(4);
    chk("R5 irq stays low with global off", int'(irq), 0);
    wr_reg(2'd0, 8'h20);
    wr_reg(2'd0, 8'hA0);
    expect_entry(3);
    t0_evt = 1'b1; @(negedge clk); t0_evt = 1'b0;
    idle(20);
    rd_reg(2'd0, rd); chk("R7 global enable cleared on entry", rd, 8'h24);
    chk("R7 irq low after entry", int'(irq), 0);

    // R8 return strobe restores global enable
    wr_reg(2'd0, 8'h20);
    reti = 1'b1; @(negedge clk); reti = 1'b0;
    rd_reg(2'd0, rd); chk("R8 reti sets global enable", rd, 8'hA0);
    wr_reg(2'd0, 8'h00);

    // R5 peripheral gating by group enable
    wr_reg(2'd1, 8'h08);
    wr_reg(2'd0, 8'h80);
    per_evt = 8'h08; @(negedge clk); per_evt = '0; idle(8);
    chk("R5 peripheral blocked without group enable", int'(irq), 0);
    rd_reg(2'd2, rd); chk("R3 peripheral flag set", rd, 8'h08);
    expect_entry(3);
    wr_reg(2'd0, 8'hC0);
    idle(20);
    rd_reg(2'd0, rd); chk("R7 global enable cleared after peripheral entry", rd, 8'h40);

    // R6 entry from the external pin
    wr_reg(2'd2, 8'h00);
    wr_reg(2'd1, 8'h00);
    wr_reg(2'd0, 8'h90);
    expect_entry(5);
    ext_pin = 1'b1;
    idle(24);
    ext_pin = 1'b0;
    rd_reg(2'd0, rd); chk("R6 pin entry flags and enable", rd, 8'h12);

    idle(4);
    chk("R6 all expected vector loads seen", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule